// File: doc/BRIEF.md
# Keyed Watchdog Timer with Selectable Timeout Action

This block is a watchdog counter that runs on a slow oscillator clock. Software controls it through two byte-wide registers. The control register is at offset 0 and the status register is at offset 1.

The counter runs only while a 4-bit run key in the control register holds a value other than the stop code `4'b1010`. Writing the restart bit zeroes the counter, which begins a fresh period. If the counter reaches the end of its period before software restarts it, the block raises a one-cycle request. The request is a non-maskable interrupt or a system reset, chosen by a mode bit in the status register. A sticky flag records that an interrupt-mode timeout occurred. Only a restart clears that flag.

After a timeout the counter wraps to zero and keeps counting. Timeouts therefore repeat every period until software restarts the watchdog. When the oscillator clock is gated off, the counter simply freezes.

Top module: `keyed_wdog`

## Requirements
- R1: After a synchronous reset, the run key reads `4'b1010` (stopped), the mode bit and the flag read 0, and no request pulse is produced. Control reads `8'h0A` and status reads `8'h00`.
- R2: While the run key (control offset 0, bits [3:0]) equals `4'b1010`, the counter holds its value. Any other key makes it advance by one per clock.
- R3: Writing 1 to control bit 4 zeroes the counter in that cycle. The bit is not stored and always reads back as 0.
- R4: While the counter runs, a timeout pulse appears exactly 2^CNT_W clock edges after the edge of the last restart. It then repeats every 2^CNT_W edges until the next restart.
- R5: Status bit 1 selects the timeout action: 0 pulses `nmi_pulse` and 1 pulses `reset_pulse`. Each pulse lasts one cycle, and the two never coincide.
- R6: Status bit 0 is set in the same cycle as an `nmi_pulse`. A reset-mode timeout does not set it, and software writes to it have no effect.
- R7: Status bit 0 is cleared only by a restart, in the cycle of the restart write.
- R8: A counter started without a restart resumes from its held count. The first timeout therefore comes 2^CNT_W minus the held count edges after the start write.
- R9: A restart written at the same edge where the counter would overflow wins. No pulse is raised, the flag is not set, and the next timeout comes one full period later.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Oscillator clock; the counter freezes while it is gated |
| rst_n | input | 1 | Synchronous active-low reset |
| reg_wr | input | 1 | Single-cycle register write strobe |
| reg_addr | input | ADDR_W | Register offset: 0 is control, 1 is status |
| reg_wdata | input | 8 | Write data |
| reg_rdata | output | 8 | Read data for the addressed register (combinational) |
| nmi_pulse | output | 1 | One-cycle non-maskable interrupt request on a timeout |
| reset_pulse | output | 1 | One-cycle system reset request on a timeout |

## Verification
The properties take for granted the following:
- Writes arrive as one-cycle strobes on the same clock as the counter.
- Reset is asserted at the first edge.
- Restarts are the only path that zeroes the counter.

The stimulus writes only offsets 0 and 1, always through a one-cycle write task. It places every restart on an edge chosen relative to the edge number of the previous write, including the exact overflow edge. A narrow counter width keeps each period short, so the bench can observe several wraps, a resume from a held count, and a restart that collides with an overflow.

// File: rtl/wdog_pkg.sv
// Package: shared constants and types for the keyed watchdog.
// Assumes byte-wide registers and a single-bit-per-field layout.
package wdog_pkg;
    localparam int          REG_W       = 8;
    localparam int          KEY_W       = 4;
    localparam logic [3:0]  STOP_CODE   = 4'b1010;
    localparam int          CTL_OFS     = 0;
    localparam int          STAT_OFS    = 1;
    localparam int          RESTART_BIT = 4;
    localparam int          MODE_BIT    = 1;
    localparam int          FLAG_BIT    = 0;

    typedef enum logic {
        ACT_NMI   = 1'b0,
        ACT_RESET = 1'b1
    } wdog_act_e;
endpackage

// File: rtl/wdog_regs.sv
// Module: register decode for the watchdog.
// Holds the run key and the mode bit, turns the restart bit into a pulse,
// and muxes read data. Assumes reg_wr is a one-cycle strobe.
module wdog_regs
    import wdog_pkg::*;
#(
    parameter int ADDR_W = 1
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              reg_wr,
    input  logic [ADDR_W-1:0] reg_addr,
    input  logic [REG_W-1:0]  reg_wdata,
    input  logic              flag,
    output logic [KEY_W-1:0]  run_code,
    output logic              running,
    output logic              restart,
    output wdog_act_e         mode,
    output logic [REG_W-1:0]  reg_rdata
);
    localparam logic [ADDR_W-1:0] A_CTL  = ADDR_W'(CTL_OFS);
    localparam logic [ADDR_W-1:0] A_STAT = ADDR_W'(STAT_OFS);

    logic wr_ctl, wr_stat;
    logic unused_wdata;

    assign wr_ctl       = reg_wr && (reg_addr == A_CTL);
    assign wr_stat      = reg_wr && (reg_addr == A_STAT);
    assign restart      = wr_ctl && reg_wdata[RESTART_BIT];
    assign running      = (run_code != STOP_CODE);
    assign unused_wdata = ^reg_wdata[REG_W-1:RESTART_BIT+1];

    // Store the run key on a control write.
    always_ff @(posedge clk) begin
        if (!rst_n)      run_code <= STOP_CODE;
        else if (wr_ctl) run_code <= reg_wdata[KEY_W-1:0];
    end

    // Store the action select on a status write.
    always_ff @(posedge clk) begin
        if (!rst_n)       mode <= ACT_NMI;
        else if (wr_stat) mode <= wdog_act_e'(reg_wdata[MODE_BIT]);
    end

    // Read mux: the restart bit is not stored and reads as zero.
    always_comb begin
        reg_rdata = '0;
        if (reg_addr == A_CTL) begin
            reg_rdata[KEY_W-1:0] = run_code;
        end else if (reg_addr == A_STAT) begin
            reg_rdata[MODE_BIT] = mode;
            reg_rdata[FLAG_BIT] = flag;
        end
    end
endmodule

// File: rtl/wdog_count.sv
// Module: period counter for the watchdog.
// Counts while running and wraps at its all-ones value, where it flags expiry.
// A restart zeroes it and overrides expiry in the same cycle.
module wdog_count #(
    parameter int CNT_W = 17
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             running,
    input  logic             restart,
    output logic [CNT_W-1:0] cnt,
    output logic             expire
);
    localparam logic [CNT_W-1:0] CNT_MAX = {CNT_W{1'b1}};

    assign expire = running && !restart && (cnt == CNT_MAX);

    // Advance, hold or clear the count; the natural wrap restarts the period.
    always_ff @(posedge clk) begin
        if (!rst_n)       cnt <= '0;
        else if (restart) cnt <= '0;
        else if (running) cnt <= cnt + 1'b1;
    end
endmodule

// File: rtl/wdog_action.sv
// Module: timeout action and sticky status for the watchdog.
// Turns an expiry into a registered one-cycle request of the selected kind.
// Keeps a flag for interrupt-mode timeouts that only a restart clears.
module wdog_action
    import wdog_pkg::*;
(
    input  logic      clk,
    input  logic      rst_n,
    input  logic      expire,
    input  logic      restart,
    input  wdog_act_e mode,
    output logic      nmi_pulse,
    output logic      reset_pulse,
    output logic      flag
);
    // Register the request pulses so each lasts exactly one cycle.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            nmi_pulse   <= 1'b0;
            reset_pulse <= 1'b0;
        end else begin
            nmi_pulse   <= expire && (mode == ACT_NMI);
            reset_pulse <= expire && (mode == ACT_RESET);
        end
    end

    // Sticky flag: set by an interrupt-mode timeout, cleared by a restart.
    always_ff @(posedge clk) begin
        if (!rst_n)                             flag <= 1'b0;
        else if (restart)                       flag <= 1'b0;
        else if (expire && (mode == ACT_NMI))   flag <= 1'b1;
    end
endmodule

// File: rtl/keyed_wdog.sv
// Module: top of the keyed watchdog timer.
// Joins the register decode, the period counter and the action stage.
// Assumes the whole block runs on the oscillator clock, including the register port.
module keyed_wdog
    import wdog_pkg::*;
#(
    parameter int CNT_W  = 17,
    parameter int ADDR_W = 1
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              reg_wr,
    input  logic [ADDR_W-1:0] reg_addr,
    input  logic [7:0]        reg_wdata,
    output logic [7:0]        reg_rdata,
    output logic              nmi_pulse,
    output logic              reset_pulse
);
    logic [KEY_W-1:0] run_code;
    logic             running;
    logic             restart;
    wdog_act_e        mode;
    logic             flag;
    logic [CNT_W-1:0] cnt;
    logic             expire;

    wdog_regs #(.ADDR_W(ADDR_W)) u_regs (
        .clk       (clk),
        .rst_n     (rst_n),
        .reg_wr    (reg_wr),
        .reg_addr  (reg_addr),
        .reg_wdata (reg_wdata),
        .flag      (flag),
        .run_code  (run_code),
        .running   (running),
        .restart   (restart),
        .mode      (mode),
        .reg_rdata (reg_rdata)
    );

    wdog_count #(.CNT_W(CNT_W)) u_count (
        .clk     (clk),
        .rst_n   (rst_n),
        .running (running),
        .restart (restart),
        .cnt     (cnt),
        .expire  (expire)
    );

    wdog_action u_action (
        .clk         (clk),
        .rst_n       (rst_n),
        .expire      (expire),
        .restart     (restart),
        .mode        (mode),
        .nmi_pulse   (nmi_pulse),
        .reset_pulse (reset_pulse),
        .flag        (flag)
    );
endmodule

// File: rtl/wdog_chk.sv
// Checker: temporal properties of the keyed watchdog, attached by bind.
// Assumes single-clock operation and a reset asserted at the first edge.
module wdog_chk
    import wdog_pkg::*;
#(
    parameter int CNT_W = 17
) (
    input logic             clk,
    input logic             rst_n,
    input logic [KEY_W-1:0] run_code,
    input logic             restart,
    input logic [CNT_W-1:0] cnt,
    input logic             mode,
    input logic             flag,
    input logic             nmi_pulse,
    input logic             reset_pulse
);
    localparam logic [CNT_W-1:0] CNT_MAX = {CNT_W{1'b1}};

    p_reset_state_r1: assert property (@(posedge clk)
        !rst_n |=> (run_code == STOP_CODE) && !mode && !flag && !nmi_pulse && !reset_pulse);

    p_hold_stopped_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (run_code == STOP_CODE) && !restart |=> $stable(cnt));

    p_restart_zero_r3: assert property (@(posedge clk) disable iff (!rst_n)
        restart |=> (cnt == '0));

    p_tick_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (run_code != STOP_CODE) && !restart && (cnt != CNT_MAX)
        |=> (cnt == $past(cnt) + 1'b1) && !nmi_pulse && !reset_pulse);

    p_exclusive_r5: assert property (@(posedge clk) disable iff (!rst_n)
        !(nmi_pulse && reset_pulse));

    p_nmi_single_r5: assert property (@(posedge clk) disable iff (!rst_n)
        nmi_pulse |=> !nmi_pulse);

    p_rst_single_r5: assert property (@(posedge clk) disable iff (!rst_n)
        reset_pulse |=> !reset_pulse);

    p_flag_source_r6: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(flag) |-> nmi_pulse);

    p_flag_clear_r7: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(flag) |-> $past(restart));

    p_restart_wins_r9: assert property (@(posedge clk) disable iff (!rst_n)
        restart |=> !nmi_pulse && !reset_pulse && !$rose(flag));
endmodule

bind keyed_wdog wdog_chk #(.CNT_W(CNT_W)) u_chk (
    .clk         (clk),
    .rst_n       (rst_n),
    .run_code    (run_code),
    .restart     (restart),
    .cnt         (cnt),
    .mode        (mode),
    .flag        (flag),
    .nmi_pulse   (nmi_pulse),
    .reset_pulse (reset_pulse)
);

// File: tb/keyed_wdog_tb.sv
`timescale 1ns/1ps
// Bench: a scoreboard of expected timeout pulses (kind and edge number)
// that a monitor pops as pulses appear; register reads are checked directly.
module keyed_wdog_tb;
    localparam int W = 6;
    localparam int P = 1 << W;

    typedef struct {
        bit          is_rst;
        int unsigned at;
    } ev_t;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       reg_wr = 1'b0;
    logic [0:0] reg_addr = 1'b0;
    logic [7:0] reg_wdata = 8'h00;
    logic [7:0] reg_rdata;
    logic       nmi_pulse, reset_pulse;

    int unsigned cyc = 0;
    int          total = 0;
    int          bad = 0;
    ev_t         q[$];

    keyed_wdog #(.CNT_W(W), .ADDR_W(1)) u_dut (
        .clk         (clk),
        .rst_n       (rst_n),
        .reg_wr      (reg_wr),
        .reg_addr    (reg_addr),
        .reg_wdata   (reg_wdata),
        .reg_rdata   (reg_rdata),
        .nmi_pulse   (nmi_pulse),
        .reset_pulse (reset_pulse)
    );

    always #10 clk = ~clk;

    // Edge counter: holds the number of the most recent rising edge.
    always @(posedge clk) cyc <= cyc + 1;

    // Monitor: every pulse must match the next expected item.
    always @(negedge clk) begin
        if (rst_n && (nmi_pulse || reset_pulse)) begin
            total++;
            if (q.size() == 0) begin
                bad++;
                $display("FAIL R4/R5: unexpected pulse nmi=%0b rst=%0b at edge %0d, expected none",
                         nmi_pulse, reset_pulse, cyc);
            end else begin
                ev_t e;
                e = q.pop_front();
                if (e.at != cyc || nmi_pulse != !e.is_rst || reset_pulse != e.is_rst) begin
                    bad++;
                    $display("FAIL R4/R5: pulse nmi=%0b rst=%0b at edge %0d, expected rst=%0b at edge %0d",
                             nmi_pulse, reset_pulse, cyc, e.is_rst, e.at);
                end
            end
        end
    end

    task automatic push(input bit is_rst, input int unsigned at);
        ev_t e;
        e.is_rst = is_rst;
        e.at     = at;
        q.push_back(e);
    endtask

    // One-cycle write; returns the number of the edge that takes it.
    task automatic wr(input logic a, input logic [7:0] d, output int unsigned edge_no);
        reg_wr    = 1'b1;
        reg_addr  = a;
        reg_wdata = d;
        edge_no   = cyc + 1;
        @(posedge clk);
        @(negedge clk);
        reg_wr = 1'b0;
    endtask

    // Write timed so that it is taken at a chosen edge.
    task automatic wr_at(input logic a, input logic [7:0] d, input int unsigned target);
        int unsigned e;
        while (cyc + 1 < target) @(negedge clk);
        wr(a, d, e);
    endtask

    task automatic wait_edge(input int unsigned target);
        while (cyc < target) @(negedge clk);
    endtask

    task automatic rd(input logic a, input logic [7:0] exp, input string req);
        reg_addr = a;
        #1;
        total++;
        if (reg_rdata !== exp) begin
            bad++;
            $display("FAIL %s: read offset %0d got %h expected %h", req, a, reg_rdata, exp);
        end
    endtask

    // Watchdog: a hung run counts as a failure and still reports.
    initial begin
        repeat (150000) @(posedge clk);
        total++;
        bad++;
        $display("FAIL watchdog: run did not finish, got timeout expected completion");
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        int unsigned e, wl, ws, we;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        // R1: state after reset
        rd(1'b0, 8'h0A, "R1");
        rd(1'b1, 8'h00, "R1");
        // R2: stopped key holds the counter; no pulse during a long idle
        repeat (150) @(negedge clk);
        rd(1'b1, 8'h00, "R2");

        // R4: restart plus run, then two periods of interrupt pulses
        wr(1'b0, 8'h10, e);
        push(1'b0, e + P);
        push(1'b0, e + 2 * P);
        wait_edge(e + 2 * P + 2);
        rd(1'b1, 8'h01, "R6");
        rd(1'b0, 8'h00, "R3");

        // R7: a restart clears the flag; periodic restarts hold off timeouts
        wr(1'b0, 8'h10, wl);
        rd(1'b1, 8'h00, "R7");
        for (int i = 0; i < 3; i++) begin
            repeat (40) @(negedge clk);
            wr(1'b0, 8'h10, wl);
        end

        // R8: stop with count 50 held, idle, then resume without restart
        ws = wl + 50;
        wr_at(1'b0, 8'h0A, ws);
        repeat (100) @(negedge clk);
        rd(1'b0, 8'h0A, "R2");
        rd(1'b1, 8'h00, "R8");
        wr(1'b0, 8'h05, we);
        push(1'b0, we + P - 50);
        wait_edge(we + P - 50 + 2);
        rd(1'b1, 8'h01, "R8");

        // R5: reset mode, restart, one reset pulse, flag stays clear (R6)
        wr(1'b1, 8'h02, e);
        wr(1'b0, 8'h15, e);
        rd(1'b1, 8'h02, "R7");
        rd(1'b0, 8'h05, "R3");
        push(1'b1, e + P);
        wait_edge(e + P + 2);
        rd(1'b1, 8'h02, "R6");

        // R9: back to interrupt mode; restart lands on the overflow edge
        wr(1'b1, 8'h00, ws);
        wr_at(1'b0, 8'h15, e + 2 * P);
        @(negedge clk);
        rd(1'b1, 8'h00, "R9");
        push(1'b0, e + 3 * P);
        wait_edge(e + 3 * P + 2);
        rd(1'b1, 8'h01, "R9");

        // R6: software cannot clear or set the flag
        wr(1'b1, 8'h00, ws);
        rd(1'b1, 8'h01, "R6");
        wr(1'b0, 8'h1A, ws);
        rd(1'b1, 8'h00, "R7");
        rd(1'b0, 8'h0A, "R2");
        wr(1'b1, 8'h01, ws);
        rd(1'b1, 8'h00, "R6");
        repeat (200) @(negedge clk);

        total++;
        if (q.size() != 0) begin
            bad++;
            $display("FAIL R4: %0d expected pulses missing, expected 0", q.size());
        end
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule